// File: doc/BRIEF.md
# Synchronous Flow-Through Burst SRAM

A behavioural, synthesizable model of a single-ported synchronous static RAM with a 36-bit data path. The data path is split into four 9-bit byte lanes. Every control input is sampled on the rising clock edge. A read shows the addressed word during the cycle that follows the edge that selected it, with no extra pipeline stage. The array holds 2^ADDR_W words.

A host starts a burst with one of two address strobes. The processor-side strobe always begins a read. The controller-side strobe can begin either a read or a write. After that, a two-bit counter walks through the other three words of the aligned group of four, in linear or interleaved order. An advance input steps the counter and can pause it. Write cycles are decoded from a global write, a byte-write enable and four per-lane enables. Three chip enables allow depth expansion. The bus has no inout pin; the block drives a separate read-data output together with a drive flag.

Top module: `sync_burst_sram`

## Requirements
- R1: Synchronous active-high reset leaves the device deselected with `dq_drive` low and `rdata` all zeros.
- R2: An edge with `proc_as_n` low and `ce1_n` low loads `addr` as the burst start and begins a read. Byte-write inputs are ignored on that edge. If `ce2` is high and `ce3_n` is low, the word at `addr` appears on `rdata` right after that edge. Otherwise the device is deselected.
- R3: An edge with `ctrl_as_n` low that is not a processor load (R2) loads `addr`. If all three chip enables are active, that edge performs a read or a write at `addr`, as decoded by R4.
- R4: Write lanes are decoded as follows. `gw_n` low writes all four lanes. Otherwise, `bwe_n` low writes each lane i for which `bw_n[i]` is low; lane i is bits 9i+8..9i of `wdata`. Every other combination, including `bwe_n` low with all `bw_n` high, is a read.
- R5: An edge with no load and `adv_n` low advances the burst count by one. The low two address bits become (start+count) mod 4 when `burst_mode` is 0 (linear), and start XOR count when it is 1 (interleaved). The upper address bits keep their start value. Each such edge reads or writes the new address as decoded by R4.
- R6: The fourth advance after a load returns the address to the start word.
- R7: An edge with no load and `adv_n` high keeps the current address (suspend). The access on that edge reads or writes that same word.
- R8: `dq_drive` is high exactly when the device is selected, the bus is not held in high-Z by R9, and `oe_n` is low. `oe_n` acts without waiting for a clock edge. `rdata` is zero whenever `dq_drive` is low.
- R9: Any write edge floats the bus, whatever the level of `oe_n`. The bus stays floating through later non-load reads until a strobe load starts a selected read.
- R10: A controller-strobe load with any chip enable inactive deselects the device. Until the next selecting load, the bus is not driven and write cycles change no memory word.
- R11: A processor strobe with `ce1_n` high is ignored. The edge is handled as the controller strobe or as a burst continuation would be.
- R12: `ce2` and `ce3_n` matter only on load edges. Changing them during a burst continuation has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address, used on load edges |
| proc_as_n | input | 1 | Processor-side address strobe, active low |
| ctrl_as_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| burst_mode | input | 1 | 1 = interleaved order, 0 = linear order |
| ce1_n | input | 1 | Chip enable 1, active low |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 4 | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | 36 | Write data |
| rdata | output | 36 | Read data, zero when not driven |
| dq_drive | output | 1 | High while the block would drive the bus |

## Verification
The bench targets burst wrap in both orders from start offsets other than zero. A counter that did not reduce modulo 4, or that carried into the upper address bits, would read the wrong word on the fifth access. It starts a processor-strobe burst while every write input is asserted. A design that honoured them would corrupt the word and show it on the next read. It also checks that a read continuing after a write stays in high-Z, and that changing `oe_n` alone floats the bus at once. Further cases are deselected write continuations, an ignored processor strobe in the middle of a burst, and `ce3_n` toggling mid-burst. A design that sampled enables or strobes on the wrong edges would drive the bus or write memory where the reference model does neither.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int DATA_W = LANES * LANE_W;

    typedef logic [LANES-1:0]  lane_mask_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        ACC_CONT  = 2'd0,
        ACC_PLOAD = 2'd1,
        ACC_CLOAD = 2'd2
    } access_kind_e;

    typedef struct packed {
        logic       sel;
        logic       hz;
        logic [1:0] cnt;
    } burst_flags_t;

    function automatic logic [1:0] burst_offset(input logic [1:0] start,
                                                input logic [1:0] step,
                                                input logic       interleave);
        return interleave ? (start ^ step) : (start + step);
    endfunction

    function automatic lane_mask_t decode_lanes(input logic       gw_n,
                                                input logic       bwe_n,
                                                input lane_mask_t bw_n);
        if (!gw_n)       return '1;
        else if (!bwe_n) return ~bw_n;
        else             return '0;
    endfunction

endpackage

// File: rtl/sram_burst_ctrl.sv
module sram_burst_ctrl
    import sram_burst_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              proc_as_n,
    input  logic              ctrl_as_n,
    input  logic              adv_n,
    input  logic              burst_mode,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  lane_mask_t        bw_n,
    output lane_mask_t        wr_lanes,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              bus_ready
);

    burst_flags_t      flags_q, flags_d;
    logic [ADDR_W-1:0] base_q, base_d;
    logic [ADDR_W-1:0] cur_q, cur_d;
    access_kind_e      kind;
    lane_mask_t        lanes_dec, lanes_d;
    logic              all_en;

    always_comb begin
        all_en    = !ce1_n && ce2 && !ce3_n;
        lanes_dec = decode_lanes(gw_n, bwe_n, bw_n);
        if (!proc_as_n && !ce1_n) kind = ACC_PLOAD;
        else if (!ctrl_as_n)      kind = ACC_CLOAD;
        else                      kind = ACC_CONT;
    end

    always_comb begin
        flags_d = flags_q;
        base_d  = base_q;
        cur_d   = cur_q;
        lanes_d = '0;
        unique case (kind)
            ACC_PLOAD: begin
                flags_d.sel = ce2 && !ce3_n;
                flags_d.cnt = 2'd0;
                base_d      = addr;
                cur_d       = addr;
            end
            ACC_CLOAD: begin
                flags_d.sel = all_en;
                flags_d.cnt = 2'd0;
                base_d      = addr;
                cur_d       = addr;
                lanes_d     = all_en ? lanes_dec : '0;
            end
            default: begin
                if (flags_q.sel && !adv_n) begin
                    flags_d.cnt = flags_q.cnt + 2'd1;
                    cur_d = {base_q[ADDR_W-1:2],
                             burst_offset(base_q[1:0], flags_d.cnt, burst_mode)};
                end
                lanes_d = flags_q.sel ? lanes_dec : '0;
            end
        endcase
        if (|lanes_d)
            flags_d.hz = 1'b1;
        else if (kind != ACC_CONT && flags_d.sel)
            flags_d.hz = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '{sel: 1'b0, hz: 1'b1, cnt: 2'd0};
            base_q  <= '0;
            cur_q   <= '0;
        end else begin
            flags_q <= flags_d;
            base_q  <= base_d;
            cur_q   <= cur_d;
        end
    end

    assign wr_lanes  = lanes_d;
    assign wr_addr   = cur_d;
    assign rd_addr   = cur_q;
    assign bus_ready = flags_q.sel && !flags_q.hz;

    AST_PROC_LOAD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!proc_as_n && !ce1_n) |-> (wr_lanes == '0)); // R2

    AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (rst)
        (proc_as_n && ctrl_as_n && adv_n) |=> $stable(rd_addr)); // R7

    AST_UPPER_BITS_KEPT: assert property (@(posedge clk) disable iff (rst)
        (proc_as_n && ctrl_as_n) |=> (rd_addr[ADDR_W-1:2] == $past(rd_addr[ADDR_W-1:2]))); // R5

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array
    import sram_burst_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  lane_mask_t        wr_lanes,
    input  logic [ADDR_W-1:0] wr_addr,
    input  word_t             wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output word_t             rd_word
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_lanes[g])
                bank[wr_addr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rd_word[g*LANE_W +: LANE_W] = bank[rd_addr];
    end

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import sram_burst_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              proc_as_n,
    input  logic              ctrl_as_n,
    input  logic              adv_n,
    input  logic              burst_mode,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [3:0]        bw_n,
    input  logic              oe_n,
    input  logic [35:0]       wdata,
    output logic [35:0]       rdata,
    output logic              dq_drive
);

    lane_mask_t        wr_lanes;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic              bus_ready;
    word_t             rd_word;

    sram_burst_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .addr       (addr),
        .proc_as_n  (proc_as_n),
        .ctrl_as_n  (ctrl_as_n),
        .adv_n      (adv_n),
        .burst_mode (burst_mode),
        .ce1_n      (ce1_n),
        .ce2        (ce2),
        .ce3_n      (ce3_n),
        .gw_n       (gw_n),
        .bwe_n      (bwe_n),
        .bw_n       (bw_n),
        .wr_lanes   (wr_lanes),
        .wr_addr    (wr_addr),
        .rd_addr    (rd_addr),
        .bus_ready  (bus_ready)
    );

    sram_lane_array #(.ADDR_W(ADDR_W)) array_i (
        .clk      (clk),
        .wr_lanes (wr_lanes),
        .wr_addr  (wr_addr),
        .wdata    (wdata),
        .rd_addr  (rd_addr),
        .rd_word  (rd_word)
    );

    assign dq_drive = bus_ready && !oe_n;
    assign rdata    = dq_drive ? rd_word : '0;

    AST_FLOAT_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        (|wr_lanes) |=> !dq_drive); // R9

    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_as_n && !(!proc_as_n && !ce1_n) && (ce1_n || !ce2 || ce3_n)) |=> !dq_drive); // R10

    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !dq_drive |-> (rdata == '0)); // R8

endmodule

// File: tb/sync_burst_sram_tb.sv
module sync_burst_sram_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr;
    logic          proc_as_n, ctrl_as_n, adv_n, burst_mode;
    logic          ce1_n, ce2, ce3_n, gw_n, bwe_n, oe_n;
    logic [3:0]    bw_n;
    logic [35:0]   wdata;
    logic [35:0]   rdata;
    logic          dq_drive;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [35:0] ref_mem [WORDS];
    int r_sel = 0, r_hz = 1, r_base = 0, r_cnt = 0, r_cur = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_burst_sram #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .addr(addr), .proc_as_n(proc_as_n),
        .ctrl_as_n(ctrl_as_n), .adv_n(adv_n), .burst_mode(burst_mode),
        .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n), .bwe_n(bwe_n),
        .bw_n(bw_n), .oe_n(oe_n), .wdata(wdata), .rdata(rdata), .dq_drive(dq_drive)
    );

    task automatic idle();
        addr = '0; proc_as_n = 1; ctrl_as_n = 1; adv_n = 1;
        ce1_n = 0; ce2 = 1; ce3_n = 0; gw_n = 1; bwe_n = 1; bw_n = 4'hF;
        oe_n = 0; wdata = '0;
    endtask

    function automatic int lanes_of();
        if (!gw_n) return 15;
        if (!bwe_n) return (~bw_n) & 4'hF;
        return 0;
    endfunction

    task automatic ref_write(input int a, input int lanes);
        for (int i = 0; i < 4; i++)
            if (lanes[i]) ref_mem[a][i*9 +: 9] = wdata[i*9 +: 9];
        if (lanes != 0) r_hz = 1;
    endtask

    task automatic model_edge();
        int off;
        if (!proc_as_n && !ce1_n) begin
            r_sel = (ce2 && !ce3_n) ? 1 : 0;
            r_base = addr; r_cnt = 0; r_cur = addr;
            if (r_sel == 1) r_hz = 0;
        end else if (!ctrl_as_n) begin
            r_sel = (!ce1_n && ce2 && !ce3_n) ? 1 : 0;
            r_base = addr; r_cnt = 0; r_cur = addr;
            if (r_sel == 1) begin
                if (lanes_of() != 0) ref_write(r_cur, lanes_of());
                else r_hz = 0;
            end
        end else if (r_sel == 1) begin
            if (!adv_n) begin
                r_cnt = (r_cnt + 1) % 4;
                off = burst_mode ? ((r_base % 4) ^ r_cnt) : ((r_base % 4 + r_cnt) % 4);
                r_cur = (r_base / 4) * 4 + off;
            end
            ref_write(r_cur, lanes_of());
        end
    endtask

    task automatic compare(input string tag);
        bit exp_drv;
        logic [35:0] exp_data;
        exp_drv = (r_sel == 1) && (r_hz == 0) && !oe_n;
        exp_data = exp_drv ? ref_mem[r_cur] : 36'h0;
        checks++;
        if (dq_drive !== exp_drv) begin
            errors++;
            $display("FAIL %s dq_drive actual=%0b expected=%0b", tag, dq_drive, exp_drv);
        end
        checks++;
        if (rdata !== exp_data) begin
            errors++;
            $display("FAIL %s rdata actual=%h expected=%h", tag, rdata, exp_data);
        end
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        if (rst) begin r_sel = 0; r_hz = 1; end
        else model_edge();
        #1;
        compare(tag);
        idle();
        burst_mode = burst_mode;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        idle();
        burst_mode = 0;
        for (int i = 0; i < WORDS; i++) ref_mem[i] = '0;
        rst = 1;
        step("R1"); step("R1");
        rst = 0;
        step("R1");

        // R3/R4: fill every word with a global write through the controller strobe
        for (int a = 0; a < WORDS; a++) begin
            ctrl_as_n = 0; addr = a[AW-1:0]; gw_n = 0;
            wdata = {4{a[8:0] ^ 9'h0A5}} ^ 36'h3C3C3C3C3;
            step("R3");
        end

        // R2/R5/R6: linear burst from offset 1, wrap on the fourth advance
        burst_mode = 0;
        proc_as_n = 0; addr = 8'h15; step("R2");
        for (int k = 0; k < 5; k++) begin burst_mode = 0; adv_n = 0; step(k == 3 ? "R6" : "R5"); end

        // R5/R6: interleaved burst from offset 2
        burst_mode = 1;
        proc_as_n = 0; addr = 8'h2E; step("R2");
        for (int k = 0; k < 5; k++) begin burst_mode = 1; adv_n = 0; step(k == 3 ? "R6" : "R5"); end
        // R7: suspend holds the word
        burst_mode = 1; step("R7");
        burst_mode = 1; step("R7");
        burst_mode = 1; adv_n = 0; step("R5");

        // R2: processor load ignores every write input
        burst_mode = 0;
        proc_as_n = 0; addr = 8'h40; gw_n = 0; bwe_n = 0; bw_n = 4'h0;
        wdata = 36'hFFFFFFFFF; step("R2");
        ctrl_as_n = 0; addr = 8'h40; step("R2");

        // R4: lane 0 and lane 2 only, then readback
        ctrl_as_n = 0; addr = 8'h50; bwe_n = 0; bw_n = 4'b1010; wdata = 36'h123456789; step("R4");
        ctrl_as_n = 0; addr = 8'h50; step("R4");
        // R4: bwe low with no lane enabled is a read
        ctrl_as_n = 0; addr = 8'h51; bwe_n = 0; bw_n = 4'hF; wdata = 36'h0; step("R4");
        // R4: global write overrides lane enables
        ctrl_as_n = 0; addr = 8'h52; bwe_n = 0; bw_n = 4'hE; gw_n = 0; wdata = 36'hABCDEF012; step("R4");
        ctrl_as_n = 0; addr = 8'h52; step("R4");

        // R9: write burst, then reads continuing the burst stay floating
        ctrl_as_n = 0; addr = 8'h61; gw_n = 0; wdata = 36'h111111111; step("R9");
        adv_n = 0; bwe_n = 0; bw_n = 4'h0; wdata = 36'h222222222; step("R9");
        adv_n = 0; bwe_n = 0; bw_n = 4'h7; wdata = 36'h333333333; step("R9");
        adv_n = 0; step("R9");
        step("R9");
        proc_as_n = 0; addr = 8'h61; step("R9");
        adv_n = 0; step("R9");
        adv_n = 0; step("R9");

        // R8: output enable acts without a clock edge
        oe_n = 1; #1; compare("R8");
        oe_n = 0; #1; compare("R8");
        oe_n = 1; step("R8");

        // R10: deselect via ce2, later write continuations change nothing
        ctrl_as_n = 0; addr = 8'h70; ce2 = 0; step("R10");
        gw_n = 0; wdata = 36'h0DEADBEEF; adv_n = 0; step("R10");
        gw_n = 0; wdata = 36'h0DEADBEEF; step("R10");
        proc_as_n = 0; addr = 8'h70; step("R10");
        adv_n = 0; step("R10");
        // R10: deselect via ce1_n on the controller strobe
        ctrl_as_n = 0; addr = 8'h72; ce1_n = 1; step("R10");
        gw_n = 0; wdata = 36'h0; step("R10");
        proc_as_n = 0; addr = 8'h72; step("R10");

        // R11: processor strobe with ce1_n high does not reload
        proc_as_n = 0; addr = 8'h84; step("R11");
        proc_as_n = 0; ce1_n = 1; addr = 8'h99; adv_n = 0; step("R11");
        proc_as_n = 0; ce1_n = 1; addr = 8'h99; step("R11");
        proc_as_n = 0; ce1_n = 1; ctrl_as_n = 0; addr = 8'h9A; step("R11");

        // R12: ce2/ce3_n toggled mid-burst have no effect
        burst_mode = 1;
        proc_as_n = 0; addr = 8'hC3; step("R12");
        burst_mode = 1; adv_n = 0; ce3_n = 1; step("R12");
        burst_mode = 1; adv_n = 0; ce2 = 0; step("R12");
        burst_mode = 1; adv_n = 0; ce3_n = 1; ce2 = 0; step("R12");

        // R1: reset in the middle of a burst
        rst = 1; step("R1");
        rst = 0; step("R1");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule